// File: doc/BRIEF.md
# Threshold Watchdog with Per-Channel Fast Sinc Filter

This block watches a data stream against two programmable signed limits and reports every crossing. It runs on its own and does not depend on the main conversion path. It has two kinds of source. The first is the main filter's output words, taken as they arrive. The second is the raw one-bit serial streams of a set of channels. Each selected channel has its own small sinc filter. The order of this filter is selectable from one to three, and its decimation ratio is programmable from 1 to 32. These filters let the monitor react quickly while the main filter is doing something else.

Each crossing sets a sticky flag for the channel concerned. There is one flag for values below the low limit and another for values above the high limit. Software clears a flag by writing a one to it. Whenever any flag is set, the block drives an interrupt request and a break line, and each of these has its own enable.

Top module: `awd_monitor`

## Requirements
- R1: A synchronous active-high reset clears every flag, so that `irq` and `brk` are low after the reset edge.
- R2: When `en`=1 and `src_sel`=0, each `main_valid` word is compared at the edge that samples it. A word below `thr_lo` sets `flag_lo[0]`, and a word above `thr_hi` sets `flag_hi[0]`. Both comparisons are two's-complement signed.
- R3: A value exactly equal to `thr_lo` or `thr_hi` sets no flag, for both the main source and the channel filters.
- R4: When `en`=1 and `src_sel`=1, a channel with `ch_mask[i]`=1 maps each strobed bit to +1 (bit 1) or -1 (bit 0). The channel filter computes the sum of the last R samples, applied K times in cascade, where R = `osr_m1`+1 and K = `ord`. An `ord` code of 0 acts as order 1. The filter emits a result after every R-th strobe. That result is compared against the thresholds at the following edge, so its flag shows two edges after the completing strobe.
- R5: Each channel sets only its own bit i of `flag_lo`/`flag_hi`. A channel whose mask bit is 0 sets no flag, and its filter is held cleared.
- R6: A flag remains set until a one is written to its bit of `clr_lo`/`clr_hi`; a zero in the clear word changes nothing. If a set and a clear reach the same bit at the same edge, the set wins.
- R7: `irq` is high exactly when `irq_en`=1 and at least one flag is set. `brk` follows the same rule with `brk_en`.
- R8: With `en`=0, no new flag is set from either source, all channel filters are cleared, and existing flags keep their value.
- R9: With order 3 and R = 32, a channel that carries only ones settles at +32768. This value sets the high flag when `thr_hi` is 32767 and leaves it clear when `thr_hi` is 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable |
| src_sel | input | 1 | 0: main data words, 1: serial channels |
| ch_mask | input | NCH | Channel selection when src_sel=1 |
| ord | input | 2 | Channel filter order (0 and 1 both give order 1) |
| osr_m1 | input | 5 | Channel decimation ratio minus one |
| thr_lo | input | DW | Signed low threshold |
| thr_hi | input | DW | Signed high threshold |
| main_valid | input | 1 | Main data word valid |
| main_data | input | DW | Signed main data word |
| ch_bit | input | NCH | Serial data bit per channel |
| ch_stb | input | NCH | Serial bit strobe per channel |
| clr_lo | input | NCH | Write-one-to-clear for the low flags |
| clr_hi | input | NCH | Write-one-to-clear for the high flags |
| irq_en | input | 1 | Interrupt enable |
| brk_en | input | 1 | Break enable |
| flag_lo | output | NCH | Sticky below-low flags per channel |
| flag_hi | output | NCH | Sticky above-high flags per channel |
| irq | output | 1 | Interrupt request |
| brk | output | 1 | Break output |

## Verification
The only state hidden inside this block is in the channel integrators, the comb delays and the decimation counters. A fault in any of them produces a wrong decimated value, or a value at the wrong strobe. That error reaches the ports as a flag that appears or fails to appear, no more than R strobes plus two edges after the fault. Limits are placed close to the expected filter output so that small errors also flip a flag. Every edge is compared against an independent moving-sum model, so the first clock at which a flag or the interrupt or break line differs from the model is reported.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int OSR_W   = 5;
    localparam int MAX_OSR = 1 << OSR_W;
    localparam int FW      = 3 * OSR_W + 2;

    typedef struct packed {
        logic                 valid;
        logic signed [FW-1:0] val;
    } filt_out_t;

    typedef struct packed {
        logic below;
        logic above;
    } cmp_res_t;

    typedef enum logic [1:0] {
        ORDER_1 = 2'd1,
        ORDER_2 = 2'd2,
        ORDER_3 = 2'd3
    } order_e;

    function automatic order_e eff_order(input logic [1:0] code);
        case (code)
            2'd2:    return ORDER_2;
            2'd3:    return ORDER_3;
            default: return ORDER_1;
        endcase
    endfunction

    function automatic int sinc_gain(input logic [OSR_W-1:0] osr_m1, input logic [1:0] code);
        int r;
        int g;
        r = int'(osr_m1) + 1;
        g = r;
        if (eff_order(code) != ORDER_1) g = g * r;
        if (eff_order(code) == ORDER_3) g = g * r;
        return g;
    endfunction

endpackage

// File: rtl/awd_sinc.sv
module awd_sinc
    import awd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [1:0]       ord,
    input  logic [OSR_W-1:0] osr_m1,
    input  logic             bit_in,
    input  logic             stb,
    output filt_out_t        fo
);

    logic signed [FW-1:0] int1, int2, int3;
    logic signed [FW-1:0] dly1, dly2, dly3;
    logic signed [FW-1:0] smp, int1_n, int2_n, int3_n;
    logic signed [FW-1:0] stage_in, comb1, comb2, comb3, comb_sel;
    logic [OSR_W-1:0]     phase;
    order_e               order;

    always_comb begin
        order  = eff_order(ord);
        smp    = bit_in ? {{(FW-1){1'b0}}, 1'b1} : {FW{1'b1}};
        int1_n = int1 + smp;
        int2_n = int2 + int1_n;
        int3_n = int3 + int2_n;
        case (order)
            ORDER_2: stage_in = int2_n;
            ORDER_3: stage_in = int3_n;
            default: stage_in = int1_n;
        endcase
        comb1 = stage_in - dly1;
        comb2 = comb1 - dly2;
        comb3 = comb2 - dly3;
        case (order)
            ORDER_2: comb_sel = comb2;
            ORDER_3: comb_sel = comb3;
            default: comb_sel = comb1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            int1     <= '0;
            int2     <= '0;
            int3     <= '0;
            dly1     <= '0;
            dly2     <= '0;
            dly3     <= '0;
            phase    <= '0;
            fo.valid <= 1'b0;
            fo.val   <= '0;
        end else begin
            fo.valid <= 1'b0;
            if (stb) begin
                int1 <= int1_n;
                int2 <= int2_n;
                int3 <= int3_n;
                if (phase == osr_m1) begin
                    phase    <= '0;
                    dly1     <= stage_in;
                    dly2     <= comb1;
                    dly3     <= comb2;
                    fo.val   <= comb_sel;
                    fo.valid <= 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    // R4
    gain_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fo.valid |-> (int'(fo.val) <= sinc_gain(osr_m1, ord) &&
                      int'(fo.val) >= -sinc_gain(osr_m1, ord)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !fo.valid);

endmodule

// File: rtl/awd_cmp.sv
module awd_cmp
    import awd_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                valid,
    input  logic signed [W-1:0] val,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output cmp_res_t            res
);

    always_comb begin
        res.below = valid && (val < lo);
        res.above = valid && (val > hi);
    end

    always_comb begin
        if (!$isunknown({valid, val, lo, hi}) && (lo <= hi)) begin
            // R3
            exclusive_chk: assert (!(res.below && res.above));
        end
    end

endmodule

// File: rtl/awd_flags.sv
module awd_flags #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_lo,
    input  logic [NCH-1:0] set_hi,
    input  logic [NCH-1:0] clr_lo,
    input  logic [NCH-1:0] clr_hi,
    output logic [NCH-1:0] flag_lo,
    output logic [NCH-1:0] flag_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_lo <= '0;
            flag_hi <= '0;
        end else begin
            flag_lo <= (flag_lo & ~clr_lo) | set_lo;
            flag_hi <= (flag_hi & ~clr_hi) | set_hi;
        end
    end

    // R6
    sticky_lo_chk: assert property (@(posedge clk) disable iff (rst)
        ((flag_lo & ~clr_lo) != '0) |=>
            ((flag_lo & $past(flag_lo & ~clr_lo)) == $past(flag_lo & ~clr_lo)));

    // R6
    sticky_hi_chk: assert property (@(posedge clk) disable iff (rst)
        ((flag_hi & ~clr_hi) != '0) |=>
            ((flag_hi & $past(flag_hi & ~clr_hi)) == $past(flag_hi & ~clr_hi)));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_lo != '0) |=> ((flag_lo & $past(set_lo)) == $past(set_lo)));

endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
    import awd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 src_sel,
    input  logic [NCH-1:0]       ch_mask,
    input  logic [1:0]           ord,
    input  logic [OSR_W-1:0]     osr_m1,
    input  logic signed [DW-1:0] thr_lo,
    input  logic signed [DW-1:0] thr_hi,
    input  logic                 main_valid,
    input  logic signed [DW-1:0] main_data,
    input  logic [NCH-1:0]       ch_bit,
    input  logic [NCH-1:0]       ch_stb,
    input  logic [NCH-1:0]       clr_lo,
    input  logic [NCH-1:0]       clr_hi,
    input  logic                 irq_en,
    input  logic                 brk_en,
    output logic [NCH-1:0]       flag_lo,
    output logic [NCH-1:0]       flag_hi,
    output logic                 irq,
    output logic                 brk
);

    localparam int EXT = DW - FW;

    filt_out_t      ch_out [NCH];
    cmp_res_t       ch_res [NCH];
    cmp_res_t       main_res;
    logic [NCH-1:0] set_lo, set_hi;
    logic           main_take;
    logic           any_flag;

    assign main_take = en && !src_sel && main_valid;

    awd_cmp #(.W(DW)) u_main_cmp (
        .valid (main_take),
        .val   (main_data),
        .lo    (thr_lo),
        .hi    (thr_hi),
        .res   (main_res)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic                 active;
        logic signed [DW-1:0] wide;

        assign active = en && src_sel && ch_mask[i];
        assign wide   = {{EXT{ch_out[i].val[FW-1]}}, ch_out[i].val};

        awd_sinc u_sinc (
            .clk    (clk),
            .rst    (rst),
            .active (active),
            .ord    (ord),
            .osr_m1 (osr_m1),
            .bit_in (ch_bit[i]),
            .stb    (ch_stb[i]),
            .fo     (ch_out[i])
        );

        awd_cmp #(.W(DW)) u_cmp (
            .valid (ch_out[i].valid),
            .val   (wide),
            .lo    (thr_lo),
            .hi    (thr_hi),
            .res   (ch_res[i])
        );
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            set_lo[i] = ch_res[i].below;
            set_hi[i] = ch_res[i].above;
        end
        set_lo[0] = set_lo[0] | main_res.below;
        set_hi[0] = set_hi[0] | main_res.above;
    end

    awd_flags #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_lo  (set_lo),
        .set_hi  (set_hi),
        .clr_lo  (clr_lo),
        .clr_hi  (clr_hi),
        .flag_lo (flag_lo),
        .flag_hi (flag_hi)
    );

    assign any_flag = (flag_lo != '0) || (flag_hi != '0);
    assign irq      = irq_en && any_flag;
    assign brk      = brk_en && any_flag;

    // R2
    main_low_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !src_sel && main_valid && (main_data < thr_lo)) |=> flag_lo[0]);

    // R2
    main_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !src_sel && main_valid && (main_data > thr_hi)) |=> flag_hi[0]);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($stable(irq_en) ? (!$past(any_flag)) : 1'b1));

endmodule

// File: tb/sim_awd_monitor.sv
module sim_awd_monitor;
    localparam int NCH = 4;
    localparam int DW  = 24;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 en, src_sel, main_valid, irq_en, brk_en;
    logic [NCH-1:0]       ch_mask, ch_bit, ch_stb, clr_lo, clr_hi;
    logic [1:0]           ord;
    logic [4:0]           osr_m1;
    logic signed [DW-1:0] thr_lo, thr_hi, main_data;
    logic [NCH-1:0]       flag_lo, flag_hi;
    logic                 irq, brk;

    int n_chk  = 0;
    int n_fail = 0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    awd_monitor #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .en(en), .src_sel(src_sel), .ch_mask(ch_mask),
        .ord(ord), .osr_m1(osr_m1), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .main_valid(main_valid), .main_data(main_data), .ch_bit(ch_bit),
        .ch_stb(ch_stb), .clr_lo(clr_lo), .clr_hi(clr_hi), .irq_en(irq_en),
        .brk_en(brk_en), .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .brk(brk)
    );

    // reference model: moving sums over a ring of past samples
    int             rx [NCH][64];
    int             ra1[NCH][64];
    int             ra2[NCH][64];
    int             ra3[NCH][64];
    int             ns  [NCH];
    bit             pv  [NCH];
    int             pval[NCH];
    logic [NCH-1:0] e_lo = '0;
    logic [NCH-1:0] e_hi = '0;

    task automatic wipe(input int i);
        for (int k = 0; k < 64; k++) begin
            rx[i][k] = 0; ra1[i][k] = 0; ra2[i][k] = 0; ra3[i][k] = 0;
        end
        ns[i] = 0;
        pv[i] = 1'b0;
    endtask

    task automatic take_sample(input int i);
        int n, r, o, s, slot;
        n    = ns[i];
        r    = int'(osr_m1) + 1;
        o    = (ord == 2'd0) ? 1 : int'(ord);
        slot = n % 64;
        rx[i][slot] = ch_bit[i] ? 1 : -1;
        s = 0; for (int k = 0; k < r; k++) s += rx[i][(n - k + 64) % 64];
        ra1[i][slot] = s;
        s = 0; for (int k = 0; k < r; k++) s += ra1[i][(n - k + 64) % 64];
        ra2[i][slot] = s;
        s = 0; for (int k = 0; k < r; k++) s += ra2[i][(n - k + 64) % 64];
        ra3[i][slot] = s;
        ns[i] = n + 1;
        if (ns[i] % r == 0) begin
            pv[i]   = 1'b1;
            pval[i] = (o == 3) ? ra3[i][slot] : (o == 2) ? ra2[i][slot] : ra1[i][slot];
        end
    endtask

    always @(posedge clk) begin
        logic [NCH-1:0] slo, shi;
        slo = '0;
        shi = '0;
        if (rst) begin
            e_lo = '0;
            e_hi = '0;
            for (int i = 0; i < NCH; i++) wipe(i);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (pv[i] && pval[i] < int'(thr_lo)) slo[i] = 1'b1;
                if (pv[i] && pval[i] > int'(thr_hi)) shi[i] = 1'b1;
            end
            if (en && !src_sel && main_valid) begin
                if (int'(main_data) < int'(thr_lo)) slo[0] = 1'b1;
                if (int'(main_data) > int'(thr_hi)) shi[0] = 1'b1;
            end
            e_lo = (e_lo & ~clr_lo) | slo;
            e_hi = (e_hi & ~clr_hi) | shi;
            for (int i = 0; i < NCH; i++) begin
                if (en && src_sel && ch_mask[i]) begin
                    pv[i] = 1'b0;
                    if (ch_stb[i]) take_sample(i);
                end else begin
                    wipe(i);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R5 flags, R7 outputs)
    always @(negedge clk) begin
        if (started) begin
            chk("R5 flag_lo vs model", int'(flag_lo), int'(e_lo));
            chk("R5 flag_hi vs model", int'(flag_hi), int'(e_hi));
            chk("R7 irq vs model", int'(irq), int'(irq_en && (e_lo != '0 || e_hi != '0)));
            chk("R7 brk vs model", int'(brk), int'(brk_en && (e_lo != '0 || e_hi != '0)));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic main_word(input int v);
        main_valid = 1'b1;
        main_data  = DW'(v);
        tick(1);
        main_valid = 1'b0;
    endtask

    task automatic clear_all();
        clr_lo = '1;
        clr_hi = '1;
        tick(1);
        clr_lo = '0;
        clr_hi = '0;
    endtask

    // mode per channel: 0 random, 1 ones, 2 zeros; strobe every div cycles
    task automatic run_ch(input int cyc, input int div, input int m0, input int m1,
                          input int m2, input int m3);
        int md[NCH];
        md[0] = m0; md[1] = m1; md[2] = m2; md[3] = m3;
        for (int c = 0; c < cyc; c++) begin
            for (int i = 0; i < NCH; i++) begin
                ch_bit[i] = (md[i] == 1) ? 1'b1 : (md[i] == 2) ? 1'b0 : 1'($urandom % 2);
            end
            ch_stb = (c % div == 0) ? '1 : '0;
            tick(1);
        end
        ch_stb = '0;
    endtask

    task automatic reconfig(input int o, input int om1, input int mask, input int lo, input int hi);
        src_sel = 1'b0;
        tick(2);
        ord     = 2'(o);
        osr_m1  = 5'(om1);
        ch_mask = NCH'(mask);
        thr_lo  = DW'(lo);
        thr_hi  = DW'(hi);
        clear_all();
        src_sel = 1'b1;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; src_sel = 1'b0; ch_mask = '0; ord = 2'd1; osr_m1 = '0;
        thr_lo = '0; thr_hi = '0; main_valid = 1'b0; main_data = '0; ch_bit = '0;
        ch_stb = '0; clr_lo = '0; clr_hi = '0; irq_en = 1'b0; brk_en = 1'b0;
        tick(3);
        started = 1'b1;
        rst = 1'b0;
        tick(1);
        chk("R1 flag_lo after reset", int'(flag_lo), 0);
        chk("R1 flag_hi after reset", int'(flag_hi), 0);
        chk("R1 irq after reset", int'(irq), 0);

        en = 1'b1; irq_en = 1'b1; brk_en = 1'b1;
        thr_lo = -24'sd100; thr_hi = 24'sd100;
        main_word(50);
        chk("R2 in-range word", int'(flag_lo | flag_hi), 0);
        main_word(-100);
        chk("R3 equal to low", int'(flag_lo), 0);
        main_word(100);
        chk("R3 equal to high", int'(flag_hi), 0);
        main_word(101);
        chk("R2 above high", int'(flag_hi), 1);
        chk("R7 irq on flag", int'(irq), 1);
        chk("R7 brk on flag", int'(brk), 1);
        main_word(-101);
        chk("R2 below low signed", int'(flag_lo), 1);
        tick(3);
        chk("R6 sticky low", int'(flag_lo), 1);
        clr_hi = 4'b0001;
        tick(1);
        clr_hi = '0;
        chk("R6 W1C high", int'(flag_hi), 0);
        chk("R6 other flag kept", int'(flag_lo), 1);
        clr_lo = 4'b0001;
        main_word(-200);
        clr_lo = '0;
        chk("R6 set beats clear", int'(flag_lo), 1);
        clr_lo = 4'b0001;
        tick(1);
        clr_lo = '0;
        chk("R6 cleared", int'(flag_lo), 0);
        irq_en = 1'b0;
        main_word(500);
        chk("R7 irq masked", int'(irq), 0);
        chk("R7 brk still on", int'(brk), 1);
        brk_en = 1'b0;
        tick(1);
        chk("R7 brk masked", int'(brk), 0);
        irq_en = 1'b1; brk_en = 1'b1;
        clear_all();

        en = 1'b0;
        main_word(500);
        main_word(-500);
        chk("R8 main ignored when disabled", int'(flag_lo | flag_hi), 0);
        en = 1'b1;

        reconfig(3, 7, 4'b0101, -300, 300);
        run_ch(200, 2, 1, 1, 2, 0);
        tick(3);
        chk("R4 ch0 ones above high", int'(flag_hi), 1);
        chk("R4 ch2 zeros below low", int'(flag_lo), 4);
        chk("R5 masked ch1 silent", int'(flag_hi[1]), 0);

        reconfig(2, 15, 4'b1111, -40, 40);
        run_ch(400, 1, 0, 0, 0, 0);
        tick(3);

        reconfig(3, 3, 4'b1111, -10, 10);
        src_sel = 1'b1;
        en = 1'b0;
        run_ch(60, 1, 1, 1, 2, 2);
        tick(3);
        chk("R8 channels ignored when disabled", int'(flag_lo | flag_hi), 0);
        en = 1'b1;

        reconfig(0, 0, 4'b0010, 0, 0);
        run_ch(5, 1, 0, 2, 0, 0);
        tick(3);
        chk("R4 order code 0 acts as order 1", int'(flag_lo), 2);

        reconfig(3, 31, 4'b0001, -40000, 32768);
        run_ch(100, 1, 1, 0, 0, 0);
        tick(3);
        chk("R9 settled value equals high", int'(flag_hi), 0);
        reconfig(3, 31, 4'b0001, -40000, 32767);
        run_ch(100, 1, 1, 0, 0, 0);
        tick(3);
        chk("R9 settled value above high", int'(flag_hi), 1);

        src_sel = 1'b0;
        tick(2);
        started = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule